// File: doc/BRIEF.md
# Processor core reset and flush control register

This block is a single 32-bit control register that sequences the reset of one processor core and requests a flush of that core's cache. Software writes it over a plain write strobe and data bus. Every write is filtered bit by bit: the upper half-word carries one enable per lower bit, so one write can change a single control bit without reading the register first. The register holds four things. Bit 0 requests core reset. Bit 4 requests a cache flush. Bits 11:8 set the length of a clock-stopped phase in ticks. Bit 12 reports that a reset sequence has completed.

A reset request runs a two-phase timed sequence. In the first phase the core reset is asserted while the core clock is gated off. In the last phase the reset is removed while the clock is still gated off. Each phase lasts until the programmed number of `tick_i` pulses has been counted. An instance parameter picks the variant. In the self-clearing variant the two phases run back to back and bit 0 drops by itself. In the held variant the core stays in reset, with its clock running, until software writes bit 0 back to 0. The flush request is raised by software and dropped by hardware when the cache signals completion.

Top module: `cpu_rst_ctl`

## Requirements
- R1: After the asynchronous reset, `rdata_o` reads 0x00000F00 (phase length 15, every other bit 0), `core_rst_o` is 0, `core_clk_en_o` is 1 and `flush_req_o` is 0.
- R2: A write with `wr_i` high changes lower bit n (n < 16) only when `wdata_i[n+16]` is 1. The phase length in bits 11:8 is taken bit by bit under enables 27:24, and it holds its value when no write occurs.
- R3: The read value has bit 0 = reset request, bit 4 = flush pending, bits 11:8 = phase length and bit 12 = done. All other bits, including the whole enable half-word, read 0, and writes aimed at them change nothing.
- R4: In the self-clearing variant, bit 0 set to 1 (with enable bit 16) starts a sequence on the next clock. First comes the assert phase, with `core_rst_o`=1 and `core_clk_en_o`=0. Then comes the release phase, with `core_rst_o`=0 and `core_clk_en_o`=0. After that the clock is re-enabled, bit 0 returns to 0 and done is set, all on the same edge.
- R5: In the self-clearing variant, writes to bit 0 while it reads 1 are ignored: a 0 does not cancel the sequence and a 1 does not restart it.
- R6: In the held variant, the assert phase is followed by a held state with `core_rst_o`=1 and `core_clk_en_o`=1. The held state lasts until software writes bit 0 to 0 with its enable. The release phase then follows and sets done.
- R7: Writing 1 to bit 12 together with enable bit 28 clears done. Writing 0, or writing without the enable, leaves done unchanged.
- R8: When a done clear is written on the same clock edge on which a sequence completes, done ends up 1.
- R9: Writing 1 to bit 4 with enable bit 20 raises `flush_req_o` on the next edge. The request holds until `flush_done_i` is sampled high, and it reads 0 on the following edge. Writing 0 to bit 4 has no effect.
- R10: A flush write while a request is pending is ignored, even on the edge where `flush_done_i` clears that request. `flush_done_i` while no request is pending is ignored.
- R11: Each clock-stopped phase lasts one clock plus the clocks needed to see L tick pulses, where L (0..15) is the phase length. With L=0 each phase is exactly one clock long.
- R12: `core_rst_o` only changes on an edge after which `core_clk_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 32 | Write data: enables in 31:16, values in 15:0 |
| rdata_o | output | 32 | Current register contents |
| tick_i | input | 1 | Time-base pulse for the clock-stopped phases |
| flush_done_i | input | 1 | Cache flush completion |
| core_rst_o | output | 1 | Core reset, active high |
| core_clk_en_o | output | 1 | Core clock enable |
| flush_req_o | output | 1 | Cache flush request |

## Verification
Done has two writers: the completion of a reset sequence sets it, and a software clear removes it. Both can land on the same edge. The bench sets the phase length to 0 so the sequence timing is known to the clock. It starts a reset and then places the clear write exactly on the edge that leaves the release phase, and it expects done to read 1 afterwards. The flush bit has the same kind of collision between `flush_done_i` and a new flush write. The bench drives both on one edge, once while a request is pending and once while none is, and a behavioural model checks the result on every clock.

// File: rtl/cpu_rst_ctl_pkg.sv
package cpu_rst_ctl_pkg;
  localparam int HALF_W    = 16;
  localparam int RST_POS   = 0;
  localparam int FLUSH_POS = 4;
  localparam int LEN_LSB   = 8;
  localparam int DONE_POS  = 12;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_ASSERT  = 2'd1,
    SEQ_HELD    = 2'd2,
    SEQ_RELEASE = 2'd3
  } seq_state_e;
endpackage

// File: rtl/cpu_rst_mask_field.sv
// Per-bit masked merge: a bit takes new data only where its enable is set.
// With cur_i tied low the output is a write-one strobe.
module cpu_rst_mask_field #(
  parameter int W = 1
) (
  input  logic         wr_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] dat_i,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign nxt_o[i] = (wr_i && en_i[i]) ? dat_i[i] : cur_i[i];
  end
endmodule

// File: rtl/cpu_rst_seq.sv
module cpu_rst_seq
  import cpu_rst_ctl_pkg::*;
#(
  parameter bit SELF_CLEAR = 1'b1,
  parameter int CNT_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             req_i,
  output logic             core_rst_o,
  output logic             clk_en_o,
  output logic             rel_end_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  seq_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             phase_end;

  // >= keeps a phase finite if the length is lowered mid-phase
  assign phase_end = (cnt_q >= len_i);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (req_i) begin
          st_d  = SEQ_ASSERT;
          cnt_d = '0;
        end
      end
      SEQ_ASSERT: begin
        if (phase_end) begin
          st_d  = (SELF_CLEAR || !req_i) ? SEQ_RELEASE : SEQ_HELD;
          cnt_d = '0;
        end else if (tick_i) begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      SEQ_HELD: begin
        if (!req_i) begin
          st_d  = SEQ_RELEASE;
          cnt_d = '0;
        end
      end
      SEQ_RELEASE: begin
        if (phase_end) st_d = SEQ_IDLE;
        else if (tick_i) cnt_d = cnt_q + CNT_ONE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign core_rst_o = (st_q == SEQ_ASSERT) || (st_q == SEQ_HELD);
  assign clk_en_o   = !((st_q == SEQ_ASSERT) || (st_q == SEQ_RELEASE));
  assign rel_end_o  = (st_q == SEQ_RELEASE) && phase_end;
endmodule

// File: rtl/cpu_rst_flush.sv
module cpu_rst_flush (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic done_i,
  output logic req_o
);
  logic req_q;

  // pending request ignores new sets; idle ignores done
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_q <= 1'b0;
    else if (req_q)     req_q <= !done_i;
    else if (set_i)     req_q <= 1'b1;
  end

  assign req_o = req_q;
endmodule

// File: rtl/cpu_rst_ctl.sv
module cpu_rst_ctl
  import cpu_rst_ctl_pkg::*;
#(
  parameter bit   SELF_CLEAR = 1'b1,
  parameter int   CNT_W      = 4,
  parameter logic [CNT_W-1:0] LEN_INIT = '1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic        tick_i,
  input  logic        flush_done_i,
  output logic        core_rst_o,
  output logic        core_clk_en_o,
  output logic        flush_req_o
);
  localparam int LEN_MSB = LEN_LSB + CNT_W - 1;
  localparam logic [HALF_W-1:0] USED_LO =
      HALF_W'((1 << RST_POS) | (1 << FLUSH_POS) | (1 << DONE_POS) |
              (((1 << CNT_W) - 1) << LEN_LSB));
  localparam logic [31:0] USED_MASK = {USED_LO, USED_LO};

  logic             rst_bit_q, rst_nxt;
  logic [CNT_W-1:0] len_q, len_nxt;
  logic             done_q, done_clr, flush_set;
  logic             rel_end;
  logic             unused_wdata;

  assign unused_wdata = ^(wdata_i & ~USED_MASK);

  cpu_rst_mask_field #(.W(1)) u_rst_field (
    .wr_i  (wr_i),
    .en_i  (wdata_i[HALF_W+RST_POS]),
    .dat_i (wdata_i[RST_POS]),
    .cur_i (rst_bit_q),
    .nxt_o (rst_nxt)
  );

  cpu_rst_mask_field #(.W(CNT_W)) u_len_field (
    .wr_i  (wr_i),
    .en_i  (wdata_i[HALF_W+LEN_MSB:HALF_W+LEN_LSB]),
    .dat_i (wdata_i[LEN_MSB:LEN_LSB]),
    .cur_i (len_q),
    .nxt_o (len_nxt)
  );

  cpu_rst_mask_field #(.W(1)) u_done_strobe (
    .wr_i  (wr_i),
    .en_i  (wdata_i[HALF_W+DONE_POS]),
    .dat_i (wdata_i[DONE_POS]),
    .cur_i (1'b0),
    .nxt_o (done_clr)
  );

  cpu_rst_mask_field #(.W(1)) u_flush_strobe (
    .wr_i  (wr_i),
    .en_i  (wdata_i[HALF_W+FLUSH_POS]),
    .dat_i (wdata_i[FLUSH_POS]),
    .cur_i (1'b0),
    .nxt_o (flush_set)
  );

  if (SELF_CLEAR) begin : g_auto
    // hardware owns the bit while it is 1
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    rst_bit_q <= 1'b0;
      else if (rel_end)               rst_bit_q <= 1'b0;
      else if (!rst_bit_q && rst_nxt) rst_bit_q <= 1'b1;
    end
  end else begin : g_held
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rst_bit_q <= 1'b0;
      else         rst_bit_q <= rst_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= LEN_INIT;
      done_q <= 1'b0;
    end else begin
      len_q <= len_nxt;
      if (rel_end)       done_q <= 1'b1;  // completion beats a clear
      else if (done_clr) done_q <= 1'b0;
    end
  end

  cpu_rst_seq #(
    .SELF_CLEAR (SELF_CLEAR),
    .CNT_W      (CNT_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .len_i      (len_q),
    .req_i      (rst_bit_q),
    .core_rst_o (core_rst_o),
    .clk_en_o   (core_clk_en_o),
    .rel_end_o  (rel_end)
  );

  cpu_rst_flush u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flush_set),
    .done_i (flush_done_i),
    .req_o  (flush_req_o)
  );

  always_comb begin
    rdata_o                  = '0;
    rdata_o[RST_POS]         = rst_bit_q;
    rdata_o[FLUSH_POS]       = flush_req_o;
    rdata_o[LEN_MSB:LEN_LSB] = len_q;
    rdata_o[DONE_POS]        = done_q;
  end
endmodule

// File: rtl/cpu_rst_ctl_chk.sv
module cpu_rst_ctl_chk
  import cpu_rst_ctl_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic [31:0] wdata_i,
  input logic [31:0] rdata_o,
  input logic        tick_i,
  input logic        flush_done_i,
  input logic        core_rst_o,
  input logic        core_clk_en_o,
  input logic        flush_req_o
);
  // R12
  rst_edge_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(core_rst_o) |-> !core_clk_en_o);

  // R9
  flush_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o && !flush_done_i |=> flush_req_o);

  // R9
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o && flush_done_i |=> !flush_req_o);

  // R10
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_req_o && !(wr_i && wdata_i[HALF_W+FLUSH_POS] && wdata_i[FLUSH_POS])
    |=> !flush_req_o);

  // R7
  done_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[HALF_W+DONE_POS] && wdata_i[DONE_POS] && core_clk_en_o
    |=> !rdata_o[DONE_POS]);

  // R4
  done_on_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_clk_en_o) && !core_rst_o |-> rdata_o[DONE_POS]);

  // R2
  len_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(rdata_o[11:8]));

  // R3
  spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & 32'hFFFF_E0EE) == 32'h0);
endmodule

bind cpu_rst_ctl cpu_rst_ctl_chk u_chk (.*);

// File: tb/cpu_rst_ctl_tb.sv
`timescale 1ns/1ps
module cpu_rst_ctl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        tick_i = 1'b0;
  logic        flush_done_i = 1'b0;
  logic [31:0] rdata [2];
  logic        crst [2];
  logic        cen [2];
  logic        freq [2];

  int n_chk = 0;
  int n_fail = 0;
  bit run_cmp = 1'b0;

  always #2 clk_i = ~clk_i;

  cpu_rst_ctl #(.SELF_CLEAR(1'b1)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata[0]), .tick_i(tick_i), .flush_done_i(flush_done_i),
    .core_rst_o(crst[0]), .core_clk_en_o(cen[0]), .flush_req_o(freq[0]));

  cpu_rst_ctl #(.SELF_CLEAR(1'b0)) u_dut_man (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .rdata_o(rdata[1]), .tick_i(tick_i), .flush_done_i(flush_done_i),
    .core_rst_o(crst[1]), .core_clk_en_o(cen[1]), .flush_req_o(freq[1]));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural model: phase 0 idle, 1 stop+reset, 2 held, 3 stop+release
  int m_ph [2], m_cnt [2], m_len [2];
  bit m_bit [2], m_done [2], m_fl [2];
  logic prev_rst [2];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < 2; k++) begin
        m_ph[k] = 0; m_cnt[k] = 0; m_len[k] = 15;
        m_bit[k] = 0; m_done[k] = 0; m_fl[k] = 0;
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        bit self_k, fin, wr_rst;
        int nph, ncnt;
        self_k = (k == 0);
        nph = m_ph[k];
        ncnt = m_cnt[k];
        fin = (m_cnt[k] >= m_len[k]);
        case (m_ph[k])
          0: if (m_bit[k]) begin nph = 1; ncnt = 0; end
          1: if (fin) begin nph = (self_k || !m_bit[k]) ? 3 : 2; ncnt = 0; end
             else if (tick_i) ncnt = m_cnt[k] + 1;
          2: if (!m_bit[k]) begin nph = 3; ncnt = 0; end
          default: if (fin) nph = 0; else if (tick_i) ncnt = m_cnt[k] + 1;
        endcase
        wr_rst = wr_i && wdata_i[16];
        if (self_k) begin
          if (m_ph[k] == 3 && fin) m_bit[k] = 0;
          else if (!m_bit[k] && wr_rst && wdata_i[0]) m_bit[k] = 1;
        end else if (wr_rst) m_bit[k] = wdata_i[0];
        if (m_ph[k] == 3 && fin) m_done[k] = 1;
        else if (wr_i && wdata_i[28] && wdata_i[12]) m_done[k] = 0;
        if (m_fl[k]) begin if (flush_done_i) m_fl[k] = 0; end
        else if (wr_i && wdata_i[20] && wdata_i[4]) m_fl[k] = 1;
        for (int b = 0; b < 4; b++)
          if (wr_i && wdata_i[24+b]) begin
            if (wdata_i[8+b]) m_len[k] = m_len[k] | (1 << b);
            else m_len[k] = m_len[k] & ~(1 << b);
          end
        m_ph[k] = nph;
        m_cnt[k] = ncnt;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && run_cmp) begin
      for (int k = 0; k < 2; k++) begin
        logic [31:0] e;
        logic er, ec;
        e = 32'h0;
        e[0] = m_bit[k]; e[4] = m_fl[k]; e[11:8] = m_len[k][3:0]; e[12] = m_done[k];
        er = (m_ph[k] == 1 || m_ph[k] == 2);
        ec = !(m_ph[k] == 1 || m_ph[k] == 3);
        if (k == 0) check(rdata[k][0] == e[0], "R5 self-clear bit0", rdata[k], e);
        else        check(rdata[k][0] == e[0], "R6 held bit0", rdata[k], e);
        check(rdata[k][11:8] == e[11:8], "R2 length field", rdata[k], e);
        check(rdata[k][12] == e[12], "R7 done bit", rdata[k], e);
        check(rdata[k][4] == e[4], "R9 flush bit", rdata[k], e);
        check((rdata[k] & 32'hFFFF_E0EE) == 32'h0, "R3 spare bits", rdata[k], 32'h0);
        if (k == 0) check({crst[k], cen[k]} == {er, ec}, "R4 rst/clk_en self",
                          {30'h0, crst[k], cen[k]}, {30'h0, er, ec});
        else        check({crst[k], cen[k]} == {er, ec}, "R6 rst/clk_en held",
                          {30'h0, crst[k], cen[k]}, {30'h0, er, ec});
        check(freq[k] == m_fl[k], "R9 flush_req_o", {31'h0, freq[k]}, {31'h0, m_fl[k]});
        if (crst[k] !== prev_rst[k])
          check(!cen[k], "R12 rst change while clock gated", {31'h0, cen[k]}, 32'h0);
        prev_rst[k] = crst[k];
      end
    end
  end

  // tick every third clock
  initial begin
    int tc;
    tc = 0;
    forever begin
      @(negedge clk_i);
      tick_i = (tc % 3 == 2);
      tc++;
    end
  end

  task automatic wr(input logic [31:0] d);
    wr_i = 1'b1;
    wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    wdata_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    prev_rst[0] = 1'b0;
    prev_rst[1] = 1'b0;
    idle(3);
    // R1 reset state
    for (int k = 0; k < 2; k++) begin
      check(rdata[k] == 32'h0000_0F00, "R1 rdata reset", rdata[k], 32'h0000_0F00);
      check({crst[k], cen[k], freq[k]} == 3'b010, "R1 outputs reset",
            {29'h0, crst[k], cen[k], freq[k]}, 32'h2);
    end
    rst_ni = 1'b1;
    idle(1);
    run_cmp = 1'b1;

    wr(32'h0F00_0200);                // R2 length 2
    wr(32'h0000_0500);                // R2 no enable, no change
    check(rdata[0][11:8] == 4'd2, "R2 unenabled write", rdata[0], 32'h200);
    wr(32'hE0EE_E0EE);                // R3 enables on spare bits
    check(rdata[0] == 32'h0000_0200, "R3 spare write", rdata[0], 32'h200);

    // R4/R5/R6 reset sequences
    wr(32'h0001_0001);
    idle(3);
    wr(32'h0001_0000);                // R5 self ignores; held releases early? no: held in assert
    wr(32'h0001_0001);                // held: re-request before leaving assert
    idle(30);
    check(rdata[0][12] && !rdata[0][0], "R4 self done and bit0 clear", rdata[0], 32'h1200);
    check(crst[0] == 1'b0 && cen[0] == 1'b1, "R4 self idle outputs",
          {30'h0, crst[0], cen[0]}, 32'h1);
    check(crst[1] == 1'b1 && cen[1] == 1'b1, "R6 held with clock running",
          {30'h0, crst[1], cen[1]}, 32'h3);
    wr(32'h0001_0000);
    idle(20);
    check(rdata[1] == 32'h0000_1200, "R6 held release done", rdata[1], 32'h1200);

    // R7 clear done
    wr(32'h0000_1000);
    check(rdata[0][12] == 1'b1, "R7 clear without enable", rdata[0], 32'h1200);
    wr(32'h1000_0000);
    check(rdata[0][12] == 1'b1, "R7 enable with zero", rdata[0], 32'h1200);
    wr(32'h1000_1000);
    check(rdata[0][12] == 1'b0, "R7 clear", rdata[0], 32'h200);

    // R11/R8 zero-length phases, clear lands on completion edge
    wr(32'h0F00_0000);
    wr(32'h0001_0001);
    check(crst[0] == 1'b0 && cen[0] == 1'b1, "R11 start latency",
          {30'h0, crst[0], cen[0]}, 32'h1);
    idle(1);
    check(crst[0] == 1'b1 && cen[0] == 1'b0, "R11 one-cycle assert phase",
          {30'h0, crst[0], cen[0]}, 32'h2);
    idle(1);
    check(crst[0] == 1'b0 && cen[0] == 1'b0, "R11 one-cycle release phase",
          {30'h0, crst[0], cen[0]}, 32'h0);
    wr(32'h1000_1000);
    check(rdata[0][12] == 1'b1 && cen[0] == 1'b1, "R8 set beats clear",
          rdata[0], 32'h1000);
    wr(32'h0001_0000);
    idle(5);

    // R9/R10 flush
    wr(32'h0010_0010);
    idle(3);
    check(freq[0] == 1'b1, "R9 flush raised and held", {31'h0, freq[0]}, 32'h1);
    wr(32'h0010_0000);
    check(freq[0] == 1'b1, "R9 software zero ignored", {31'h0, freq[0]}, 32'h1);
    wr(32'h0010_0010);
    check(freq[0] == 1'b1, "R10 rewrite while pending", {31'h0, freq[0]}, 32'h1);
    flush_done_i = 1'b1;
    wr(32'h0010_0010);
    flush_done_i = 1'b0;
    check(freq[0] == 1'b0, "R10 write with done while pending", {31'h0, freq[0]}, 32'h0);
    flush_done_i = 1'b1;
    idle(1);
    flush_done_i = 1'b0;
    check(freq[0] == 1'b0, "R10 done while idle", {31'h0, freq[0]}, 32'h0);
    flush_done_i = 1'b1;
    wr(32'h0010_0010);
    flush_done_i = 1'b0;
    check(freq[0] == 1'b1, "R10 set with stray done", {31'h0, freq[0]}, 32'h1);
    idle(2);
    flush_done_i = 1'b1;
    idle(1);
    flush_done_i = 1'b0;
    check(freq[0] == 1'b0, "R9 cleared by done", {31'h0, freq[0]}, 32'h0);

    // longer phase under the maximum length
    wr(32'h0F00_0F00);
    wr(32'h0001_0001);
    idle(120);
    check(rdata[0] == 32'h0000_1F00, "R4 full-length pulse done", rdata[0], 32'h1F00);
    idle(2);
    finish_run();
  end
endmodule